// File: doc/BRIEF.md
# Five-State Multicycle Processor Core

A small processor core that runs each instruction through one fixed sequence of five one-cycle phases: fetch, decode with operand read, ALU, memory access and write-back. There is no overlap between instructions, so every instruction takes exactly five cycles, even when a phase has no work to do. The register file holds four 16-bit general registers. Each register can be used as a whole word, as its low byte or as its high byte.

The core supports four kinds of instruction: a register-to-register add, a move of a 6-bit immediate constant, a load from a direct memory address, and a halt. Instructions and data share one word-wide memory, which sits outside the core and is read combinationally at `mem_addr`. In the memory-access phase of a load, `mem_addr` carries the memory address register. In every other phase it carries the program counter.

A write-back port shows each register update as it happens: which register is written and its full new 16-bit content. A zero flag reports the result of the most recent add.

Top module: `fetch5_core`

## Requirements
- R1: `phase` steps through 0 (fetch), 1 (decode), 2 (ALU), 3 (memory) and 4 (write-back) in that order, one cycle each, so every instruction other than halt takes exactly five cycles.
- R2: An instruction word has four fields. Bits [15:12] are the opcode, [11:9] the destination select, [8:6] the source select and [5:0] the immediate or address. Opcode bits [14:12] give the function: 1 add, 2 move immediate, 3 load, 7 halt; any other value is a no-op that writes nothing. Opcode bit 15 is the byte-mode flag.
- R3: A select names register number sel[1:0], where 0 to 3 are the A, B, C and D registers. When sel[2] is 1, the select means that register's high byte. When sel[2] is 0, it means the whole word if byte mode is 0, or the low byte if byte mode is 1.
- R4: A byte write changes only the selected half and keeps the other half. A byte read is zero-extended before it reaches the ALU.
- R5: Add writes destination + source, both read in the decode phase, truncated to the destination width. The write happens at the end of the write-back phase.
- R6: Move immediate writes the 6-bit constant, zero-extended, into the destination.
- R7: For a load, `mem_addr` equals the address field during the memory phase, and the word read there is written into the destination at write-back.
- R8: During fetch, `mem_addr` equals the program counter. The counter advances by one, modulo 64, at the end of each fetch that is not a halt.
- R9: The zero flag changes only at the end of the write-back phase of an add. It is then 1 exactly when the value written, taken at the destination width, is zero.
- R10: Fetching a halt sets `halted` and holds the core in phase 0 with the program counter frozen until reset.
- R11: Synchronous active-high reset clears all registers, the program counter, `zero` and `halted`, and selects phase 0.
- R12: `wb_valid` is high only in the write-back phase of an add, move or load. While it is high, `wb_reg` gives sel[1:0] and `wb_value` gives the register's full new content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 6 | Memory address: program counter, or the load address in the memory phase |
| mem_rdata | input | 16 | Memory word at `mem_addr` |
| phase | output | 3 | Current phase, 0 to 4 |
| halted | output | 1 | Core has stopped on a halt |
| zero | output | 1 | Last add produced zero |
| wb_valid | output | 1 | Register write this cycle |
| wb_reg | output | 2 | Register being written |
| wb_value | output | 16 | New full content of that register |

## Verification
The assertions take two things for granted. First, `mem_rdata` is defined whenever the core fetches, because the halt decision reads it. Second, reset is applied before the first instruction runs. The bench loads every memory location before it releases reset, and it ends each program with a halt word, so the core never fetches past the program. The random instructions use only the defined functions and the no-op codes, never halt. Their selects, byte-mode bit and immediates are drawn over the full range of each field, so load addresses can fall in both the code and the data areas.

// File: rtl/fetch5_core.sv
module fetch5_core #(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic [2:0]    phase,
  output logic          halted,
  output logic          zero,
  output logic          wb_valid,
  output logic [1:0]    wb_reg,
  output logic [DW-1:0] wb_value
);
  localparam int HW = DW / 2;
  localparam logic [2:0] S_FE = 3'd0, S_DE = 3'd1, S_AL = 3'd2, S_ME = 3'd3, S_WB = 3'd4;
  localparam logic [2:0] F_ADD = 3'd1, F_MOV = 3'd2, F_LD = 3'd3, F_HLT = 3'd7;

  logic [DW-1:0] rf [4];
  logic [DW-1:0] ir, op_a, op_b, res;
  logic [AW-1:0] pc, mar;

  wire       bm   = ir[15];
  wire [2:0] fn   = ir[14:12];
  wire [2:0] dsel = ir[11:9];
  wire [2:0] ssel = ir[8:6];
  wire [5:0] imm  = ir[5:0];

  wire writes = (fn == F_ADD) || (fn == F_MOV) || (fn == F_LD);
  wire narrow = dsel[2] | bm;
  wire [DW-1:0] dst_old = rf[dsel[1:0]];

  function automatic logic [DW-1:0] view(input logic [DW-1:0] w, input logic [2:0] sel,
                                         input logic bmode);
    if (sel[2]) return {{HW{1'b0}}, w[DW-1:HW]};
    if (bmode)  return {{HW{1'b0}}, w[HW-1:0]};
    return w;
  endfunction

  assign mem_addr = (phase == S_ME) ? mar : pc;
  assign wb_valid = (phase == S_WB) && writes;
  assign wb_reg   = dsel[1:0];
  assign wb_value = dsel[2] ? {res[HW-1:0], dst_old[HW-1:0]} :
                    bm      ? {dst_old[DW-1:HW], res[HW-1:0]} : res;

  wire res_zero = narrow ? (res[HW-1:0] == '0) : (res == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= S_FE;
      pc     <= '0;
      mar    <= '0;
      halted <= 1'b0;
      zero   <= 1'b0;
      ir     <= '0;
      op_a   <= '0;
      op_b   <= '0;
      res    <= '0;
      for (int i = 0; i < 4; i++) rf[i] <= '0;
    end else begin
      case (phase)
        S_FE: if (!halted) begin
          if (mem_rdata[14:12] == F_HLT) halted <= 1'b1;
          else begin
            ir    <= mem_rdata;
            pc    <= pc + 1'b1;
            phase <= S_DE;
          end
        end
        S_DE: begin
          op_a  <= view(rf[dsel[1:0]], dsel, bm);
          op_b  <= view(rf[ssel[1:0]], ssel, bm);
          phase <= S_AL;
        end
        S_AL: begin
          case (fn)
            F_ADD:   res <= op_a + op_b;
            F_MOV:   res <= {{(DW-6){1'b0}}, imm};
            F_LD:    mar <= AW'(imm);
            default: ;
          endcase
          phase <= S_ME;
        end
        S_ME: begin
          if (fn == F_LD) res <= mem_rdata;
          phase <= S_WB;
        end
        S_WB: begin
          if (writes) rf[dsel[1:0]] <= wb_value;
          if (fn == F_ADD) zero <= res_zero;
          phase <= S_FE;
        end
        default: phase <= S_FE;
      endcase
    end
  end
endmodule

// File: rtl/fetch5_core_props.sv
module fetch5_core_props #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    phase,
  input logic [AW-1:0] pc,
  input logic          halted,
  input logic          zero,
  input logic          wb_valid
);
  assert_phase_order_R1: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd1) |=> (phase == 3'd2));
  assert_phase_alu_mem_R1: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd2) |=> (phase == 3'd3));
  assert_phase_mem_wb_R1: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd3) |=> (phase == 3'd4));
  assert_phase_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd4) |=> (phase == 3'd0));
  assert_pc_step_R8: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd1) |-> (pc == AW'($past(pc) + 1'b1)));
  assert_halt_hold_R10: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && phase == 3'd0 && $stable(pc)));
  assert_zero_only_wb_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(zero) |-> ($past(phase) == 3'd4));
  assert_wb_phase_R12: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (phase == 3'd4));
  assert_reset_state_R11: assert property (@(posedge clk)
    rst |=> (phase == 3'd0 && pc == '0 && !halted && !zero));
endmodule

bind fetch5_core fetch5_core_props #(.AW(AW)) u_props (
  .clk(clk), .rst(rst), .phase(phase), .pc(pc),
  .halted(halted), .zero(zero), .wb_valid(wb_valid)
);

// File: tb/fetch5_core_test.sv
`timescale 1ns/1ps
module fetch5_core_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0]  mem_addr;
  logic [15:0] mem_rdata;
  logic [2:0]  phase;
  logic        halted, zero, wb_valid;
  logic [1:0]  wb_reg;
  logic [15:0] wb_value;
  logic [15:0] mem [64];

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;
  assign mem_rdata = mem[mem_addr];

  fetch5_core uut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .phase(phase), .halted(halted), .zero(zero),
    .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_value(wb_value)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(input logic [3:0] op, input logic [2:0] d,
                                      input logic [2:0] s, input logic [5:0] im);
    return {op, d, s, im};
  endfunction

  function automatic logic [15:0] getv(input logic [15:0] w, input logic [2:0] sel, input logic b);
    if (sel[2]) return {8'h00, w[15:8]};
    else if (b) return {8'h00, w[7:0]};
    else return w;
  endfunction

  function automatic logic [15:0] putv(input logic [15:0] old, input logic [2:0] sel,
                                       input logic b, input logic [15:0] v);
    if (sel[2]) return {v[7:0], old[7:0]};
    else if (b) return {old[15:8], v[7:0]};
    else return v;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R11 phase", 32'(phase), 0);
    chk("R11 halted", 32'(halted), 0);
    chk("R11 zero", 32'(zero), 0);
    chk("R11 pc", 32'(mem_addr), 0);
    chk("R11 wb_valid", 32'(wb_valid), 0);
  endtask

  task automatic run_prog();
    logic [15:0] m [4];
    logic [5:0]  pc;
    logic        zf;
    for (int i = 0; i < 4; i++) m[i] = 16'h0000;
    pc = '0;
    zf = 1'b0;
    do_reset();
    forever begin
      logic [15:0] ins, v, nv;
      logic [2:0]  fn, d, s;
      logic        b, wr;
      chk("R1 fetch phase", 32'(phase), 0);
      chk("R8 fetch address", 32'(mem_addr), 32'(pc));
      ins = mem[pc];
      fn = ins[14:12]; b = ins[15]; d = ins[11:9]; s = ins[8:6];
      if (fn == 3'd7) begin
        for (int k = 0; k < 5; k++) begin
          @(negedge clk);
          chk("R10 halted", 32'(halted), 1);
          chk("R10 phase", 32'(phase), 0);
          chk("R10 pc frozen", 32'(mem_addr), 32'(pc));
        end
        break;
      end
      pc = pc + 6'd1;
      @(negedge clk); chk("R1 decode", 32'(phase), 1);
      @(negedge clk); chk("R1 alu", 32'(phase), 2);
      @(negedge clk); chk("R1 mem", 32'(phase), 3);
      if (fn == 3'd3) chk("R7 load address", 32'(mem_addr), 32'(ins[5:0]));
      wr = (fn == 3'd1) || (fn == 3'd2) || (fn == 3'd3);
      case (fn)
        3'd1: v = getv(m[d[1:0]], d, b) + getv(m[s[1:0]], s, b);
        3'd2: v = {10'd0, ins[5:0]};
        3'd3: v = mem[ins[5:0]];
        default: v = 16'h0000;
      endcase
      nv = putv(m[d[1:0]], d, b, v);
      @(negedge clk);
      chk("R1 wb", 32'(phase), 4);
      chk("R2 R12 wb_valid", 32'(wb_valid), 32'(wr));
      if (wr) begin
        chk("R3 R12 wb_reg", 32'(wb_reg), 32'(d[1:0]));
        case (fn)
          3'd1: chk("R5 R4 R3 add value", 32'(wb_value), 32'(nv));
          3'd2: chk("R6 R4 move value", 32'(wb_value), 32'(nv));
          default: chk("R7 R4 load value", 32'(wb_value), 32'(nv));
        endcase
        m[d[1:0]] = nv;
      end
      if (fn == 3'd1) zf = (d[2] || b) ? (v[7:0] == 8'h00) : (v == 16'h0000);
      @(negedge clk);
      chk("R9 zero flag", 32'(zero), 32'(zf));
    end
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 64; i++) mem[i] = 16'h7000;
    mem[0]  = enc(4'h1, 3'd3, 3'd2, 6'd0);
    mem[1]  = enc(4'h3, 3'd0, 3'd0, 6'd50);
    mem[2]  = enc(4'h2, 3'd1, 3'd0, 6'd1);
    mem[3]  = enc(4'h1, 3'd0, 3'd1, 6'd0);
    mem[4]  = enc(4'h3, 3'd2, 3'd0, 6'd51);
    mem[5]  = enc(4'hA, 3'd2, 3'd0, 6'd5);
    mem[6]  = enc(4'hA, 3'd6, 3'd0, 6'd63);
    mem[7]  = enc(4'h1, 3'd3, 3'd6, 6'd0);
    mem[8]  = enc(4'h9, 3'd2, 3'd6, 6'd0);
    mem[9]  = enc(4'h3, 3'd1, 3'd0, 6'd52);
    mem[10] = enc(4'h9, 3'd5, 3'd1, 6'd0);
    mem[11] = enc(4'h3, 3'd0, 3'd0, 6'd53);
    mem[12] = enc(4'h9, 3'd0, 3'd0, 6'd0);
    mem[13] = enc(4'h0, 3'd0, 3'd1, 6'd7);
    mem[14] = enc(4'h6, 3'd1, 3'd0, 6'd0);
    mem[15] = enc(4'h7, 3'd0, 3'd0, 6'd0);
    mem[50] = 16'hFFFF;
    mem[51] = 16'h12F0;
    mem[52] = 16'hA5C1;
    mem[53] = 16'h0080;
    run_prog();
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 40; i++) begin
        logic [2:0] f;
        case ($urandom % 6)
          0: f = 3'd1;
          1: f = 3'd1;
          2: f = 3'd2;
          3: f = 3'd3;
          4: f = 3'd0;
          default: f = 3'd5;
        endcase
        mem[i] = enc({1'($urandom), f}, 3'($urandom), 3'($urandom), 6'($urandom));
      end
      mem[40] = 16'hF000;
      for (int i = 41; i < 64; i++) mem[i] = 16'($urandom);
      run_prog();
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule